// File: doc/BRIEF.md
# Serial USB Data CRC16 Generator and Checker

This block computes the 16-bit cyclic redundancy check that protects the data field of a USB data packet, one bit per strobe. A single shift register serves both directions. It is preset to all ones when a packet starts. After that it absorbs each valid serial bit, taking the bits of each byte least significant first, as they appear on the wire.

In transmit mode, payload bits pass straight to the serial output while the register absorbs them. When the end of data is signalled, a two-way select switches the serial output to the register. Sixteen complemented check bits then leave on the next sixteen strobes, most significant register bit first, and the output returns to data.

In receive mode, the register absorbs the payload followed by the received check bits. At the end-of-packet strobe it is compared with the fixed non-zero residual 0x800D. The result appears as a one-clock good or bad pulse.

Top module: `usb_crc16`

## Requirements
- R1: A start strobe (sop_i=1) presets the register to 0xFFFF, so an empty transmit packet yields sixteen check bits that are all 0. A start strobe takes precedence over a bit strobe in the same cycle.
- R2: On each cycle with bit_valid_i=1 outside the check phase, the register advances by one step of the generator x^16+x^15+x^2+1 (taps 0x8005), using bit_i as the next input bit. The bench feeds byte bits least significant first.
- R3: On cycles with bit_valid_i=0 and sop_i=0, the register holds its value, so idle gaps between strobes leave the check bits unchanged.
- R4: While crc_phase_o=0, ser_o equals bit_i in the same cycle.
- R5: In transmit mode (tx_mode_i=1), an eop_i=1 cycle starts the check phase (crc_phase_o=1) at the next edge. On each of the next 16 strobes, ser_o shows the complement of the current register MSB, and the register then shifts left. After the 16th strobe crc_phase_o returns to 0. The 16 bits equal the standard USB data CRC sent LSB first.
- R6: In receive mode (tx_mode_i=0), an eop_i=1 cycle with the register equal to 0x800D gives good_o=1 and bad_o=0 in the next cycle. eop_i compares the register as it stands at that edge.
- R7: In receive mode, an eop_i=1 cycle with any other register value gives bad_o=1 and good_o=0 in the next cycle, for example after a single corrupted bit.
- R8: good_o and bad_o are high for exactly one cycle after an end strobe and are low at all other times.
- R9: A start strobe in the middle of a packet or a check phase discards that work: crc_phase_o drops at the next edge, and a complete packet sent next is judged on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Start of packet: presets the register |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| bit_valid_i | input | 1 | Bit strobe, one per bit time |
| bit_i | input | 1 | Serial data bit |
| eop_i | input | 1 | End of data (transmit) or end of packet (receive) |
| ser_o | output | 1 | Serial output, data or check bits |
| crc_phase_o | output | 1 | High while check bits are shifted out |
| good_o | output | 1 | One-cycle pulse: residual matched |
| bad_o | output | 1 | One-cycle pulse: residual mismatched |

## Verification
The bench builds the block with its default parameters: width 16, taps 0x8005, preset all ones and residual 0x800D. These are the values of the USB data CRC, so the expected check bits can come from an independent byte-wise reflected model with taps 0xA001. With these values, an empty payload, multi-byte payloads with idle gaps, loopback into the receive path, single-bit corruption and aborted packets can all be checked against known results.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;
  localparam int unsigned CRC_W_DEF = 16;
  localparam logic [15:0] POLY_DEF = 16'h8005;
  localparam logic [15:0] RESID_DEF = 16'h800D;
  localparam logic [15:0] INIT_DEF = 16'hFFFF;

  typedef enum logic {
    PH_DATA = 1'b0,
    PH_CRC  = 1'b1
  } phase_e;
endpackage

// File: rtl/usb_crc16_core.sv
module usb_crc16_core #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] POLY = 16'h8005,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sop_i,
  input  logic         adv_i,
  input  logic         shift_only_i,
  input  logic         din_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, step_d;
  logic         fb;

  assign fb = din_i ^ crc_q[W-1];

  // one LFSR step, taps picked per bit from POLY
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == 0) begin : g_lsb
      assign step_d[i] = POLY[i] & fb;
    end else begin : g_up
      assign step_d[i] = crc_q[i-1] ^ (POLY[i] & fb);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= INIT;
    end else if (sop_i) begin
      crc_q <= INIT;
    end else if (adv_i) begin
      if (shift_only_i) crc_q <= {crc_q[W-2:0], 1'b0};
      else              crc_q <= step_d;
    end
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/usb_crc16_txseq.sv
module usb_crc16_txseq
  import usb_crc16_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sop_i,
  input  logic tx_mode_i,
  input  logic eop_i,
  input  logic adv_i,
  output logic phase_o
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  phase_e      ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_DATA;
      cnt_q <= '0;
    end else if (sop_i) begin
      ph_q  <= PH_DATA;
      cnt_q <= '0;
    end else if (ph_q == PH_DATA) begin
      if (eop_i && tx_mode_i) begin
        ph_q  <= PH_CRC;
        cnt_q <= '0;
      end
    end else if (adv_i) begin
      if (cnt_q == LAST) begin
        ph_q  <= PH_DATA;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = (ph_q == PH_CRC);
endmodule

// File: rtl/usb_crc16_rxchk.sv
module usb_crc16_rxchk #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] RESID = 16'h800D
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sop_i,
  input  logic         eval_i,
  input  logic [W-1:0] crc_i,
  output logic         good_o,
  output logic         bad_o
);
  logic match;
  assign match = (crc_i == RESID);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_o <= 1'b0;
      bad_o  <= 1'b0;
    end else if (sop_i) begin
      good_o <= 1'b0;
      bad_o  <= 1'b0;
    end else begin
      good_o <= eval_i && match;
      bad_o  <= eval_i && !match;
    end
  end
endmodule

// File: rtl/usb_crc16.sv
module usb_crc16
  import usb_crc16_pkg::*;
#(
  parameter int unsigned W     = CRC_W_DEF,
  parameter logic [W-1:0] POLY  = POLY_DEF,
  parameter logic [W-1:0] INIT  = INIT_DEF,
  parameter logic [W-1:0] RESID = RESID_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sop_i,
  input  logic tx_mode_i,
  input  logic bit_valid_i,
  input  logic bit_i,
  input  logic eop_i,
  output logic ser_o,
  output logic crc_phase_o,
  output logic good_o,
  output logic bad_o
);
  logic [W-1:0] crc_q;
  logic         phase;

  usb_crc16_core #(.W(W), .POLY(POLY), .INIT(INIT)) core_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sop_i       (sop_i),
    .adv_i       (bit_valid_i),
    .shift_only_i(phase),
    .din_i       (bit_i),
    .crc_o       (crc_q)
  );

  usb_crc16_txseq #(.W(W)) txseq_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sop_i    (sop_i),
    .tx_mode_i(tx_mode_i),
    .eop_i    (eop_i),
    .adv_i    (bit_valid_i),
    .phase_o  (phase)
  );

  usb_crc16_rxchk #(.W(W), .RESID(RESID)) rxchk_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sop_i (sop_i),
    .eval_i(eop_i && !tx_mode_i),
    .crc_i (crc_q),
    .good_o(good_o),
    .bad_o (bad_o)
  );

  // output select: payload pass-through or complemented register MSB
  assign ser_o       = phase ? ~crc_q[W-1] : bit_i;
  assign crc_phase_o = phase;
endmodule

// File: rtl/usb_crc16_chk.sv
module usb_crc16_chk #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] INIT = '1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sop_i,
  input logic         tx_mode_i,
  input logic         bit_valid_i,
  input logic         eop_i,
  input logic         crc_phase_o,
  input logic         good_o,
  input logic         bad_o,
  input logic [W-1:0] crc_q
);
  localparam int unsigned NW = $clog2(W) + 1;
  logic [NW-1:0] n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     n_q <= '0;
    else if (!crc_phase_o || sop_i)  n_q <= '0;
    else if (bit_valid_i)            n_q <= n_q + 1'b1;
  end

  // R1
  preset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i |=> crc_q == INIT);
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sop_i && !bit_valid_i) |=> $stable(crc_q));
  // R5
  phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_phase_o |-> n_q < NW'(W));
  // R8
  status_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (good_o || bad_o) |-> $past(eop_i && !tx_mode_i && !sop_i));
  // R8
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({good_o, bad_o}));
  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i |=> !crc_phase_o);
endmodule

bind usb_crc16 usb_crc16_chk #(.W(W), .INIT(INIT)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sop_i      (sop_i),
  .tx_mode_i  (tx_mode_i),
  .bit_valid_i(bit_valid_i),
  .eop_i      (eop_i),
  .crc_phase_o(crc_phase_o),
  .good_o     (good_o),
  .bad_o      (bad_o),
  .crc_q      (crc_q)
);

// File: tb/usb_crc16_tb_top.sv
module usb_crc16_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sop = 0, txm = 0, vld = 0, bi = 0, eop = 0;
  logic ser, ph, good, bad;
  int checks = 0, errors = 0;
  logic [7:0] pay [0:7];
  int plen;

  always #4 clk = ~clk;

  usb_crc16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .tx_mode_i(txm),
    .bit_valid_i(vld), .bit_i(bi), .eop_i(eop),
    .ser_o(ser), .crc_phase_o(ph), .good_o(good), .bad_o(bad)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reflected byte-wise model of the USB data CRC, bit k is sent k-th
  function automatic logic [15:0] model_crc();
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < plen; i++) begin
      c ^= {8'h00, pay[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic idle();
    @(negedge clk);
    sop = 0; vld = 0; eop = 0; bi = 0;
  endtask

  task automatic start_pkt(input logic mode);
    @(negedge clk);
    sop = 1; txm = mode; vld = 0; eop = 0;
    @(negedge clk);
    sop = 0;
  endtask

  // drives one strobe; returns ser_o seen in that cycle
  task automatic strobe(input logic b, input int gap, output logic s);
    for (int g = 0; g < gap; g++) idle();
    vld = 1; bi = b; #1 s = ser;
    @(negedge clk);
    vld = 0;
  endtask

  task automatic send_payload(input int gap, output int mism);
    logic s;
    mism = 0;
    for (int i = 0; i < plen; i++)
      for (int b = 0; b < 8; b++) begin
        strobe(pay[i][b], gap, s);
        if (s !== pay[i][b]) mism++;
      end
  endtask

  task automatic tx_test(input string tag, input int gap);
    logic [15:0] exp_c, got;
    logic s;
    int mism;
    exp_c = model_crc();
    start_pkt(1'b1);
    send_payload(gap, mism);
    chk(mism == 0, "R4 data pass-through", mism, 0);
    eop = 1;
    @(negedge clk);
    eop = 0;
    chk(ph === 1'b1, "R5 phase start", ph, 1);
    for (int k = 0; k < 16; k++) begin
      strobe(1'b0, gap, s);
      got[k] = s;
    end
    chk(got === exp_c, tag, got, exp_c);
    chk(ph === 1'b0, "R5 phase end after 16", ph, 0);
  endtask

  task automatic rx_test(input int flip, input bit garbage, input logic exp_good);
    logic [15:0] c;
    logic s;
    int mism;
    c = model_crc();
    if (garbage) begin
      start_pkt(1'b0);
      for (int k = 0; k < 11; k++) strobe(k[0] ^ k[2], 0, s);
    end
    start_pkt(1'b0);
    send_payload(0, mism);
    for (int k = 0; k < 16; k++) strobe(c[k] ^ (flip == k), 0, s);
    eop = 1;
    @(negedge clk);
    eop = 0;
    if (exp_good) chk(good === 1 && bad === 0, garbage ? "R9 restart good" : "R6 good", {good, bad}, 2);
    else          chk(good === 0 && bad === 1, "R7 bad", {good, bad}, 1);
    @(negedge clk);
    chk(good === 0 && bad === 0, "R8 one-cycle status", {good, bad}, 0);
  endtask

  task automatic reset_test();
    #1;
    chk(ph === 0 && good === 0 && bad === 0, "R8 reset state", {ph, good, bad}, 0);
  endtask

  task automatic abort_tx_test();
    logic s;
    plen = 1; pay[0] = 8'h5A;
    start_pkt(1'b1);
    for (int k = 0; k < 8; k++) strobe(pay[0][k], 0, s);
    eop = 1;
    @(negedge clk);
    eop = 0;
    strobe(1'b0, 0, s);
    sop = 1;
    @(negedge clk);
    sop = 0;
    chk(ph === 1'b0, "R9 abort check phase", ph, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        reset_test();
        rst_n = 1;
        plen = 0;
        tx_test("R1 empty payload crc", 0);
        plen = 4; pay[0] = 8'h00; pay[1] = 8'h01; pay[2] = 8'h02; pay[3] = 8'h03;
        tx_test("R2 crc of 00 01 02 03", 0);
        plen = 8;
        for (int i = 0; i < 8; i++) pay[i] = 8'(8'hA5 ^ (i * 37));
        tx_test("R2 crc of 8-byte payload", 0);
        tx_test("R3 same crc with idle gaps", 2);
        rx_test(-1, 1'b0, 1'b1);
        rx_test(5, 1'b0, 1'b0);
        plen = 0;
        rx_test(-1, 1'b0, 1'b1);
        plen = 3; pay[0] = 8'hFF; pay[1] = 8'h00; pay[2] = 8'h81;
        rx_test(-1, 1'b1, 1'b1);
        abort_tx_test();
        plen = 2; pay[0] = 8'h12; pay[1] = 8'h34;
        tx_test("R9 tx after abort", 0);
      end
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule